// File: doc/BRIEF.md
# Tiny Four-Bit Register-File Processor

This block is a very small processor that runs a fixed program. The program is held in a read-only store whose contents are fixed when the design is elaborated. Each program word is 13 bits wide, and a 9-bit program counter selects it. The processor holds eight 4-bit registers. Register 6 has no storage: reading it returns the four push-button inputs. Register 7 drives the four LED outputs directly. The remaining registers are general purpose.

The instruction set covers literal loads, copies, AND, OR, invert, add and subtract, and a one-place shift with a chosen fill bit. Four condition tests each pick one of the next two words. An unconditional jump and a wait instruction complete the set. The wait instruction stalls until a given number of pulses has arrived on an external tick input. A user pairs the block with a tick source and a program image. Together these let the block stand in for a hand-written state machine that drives LEDs from buttons.

Top module: `nib_cpu`

## Requirements
- R1: A synchronous reset clears the program counter, the wait counter, the shadow-skip state and every writable register, so `led_o` reads 0. After reset is released, execution restarts at word 0.
- R2: Word i of the image parameter sits at bits [13*i+12 : 13*i]. The word is split into fields as follows: opcode in bits 12:9, destination in 8:6, source-1 in 5:3, source-2 in 2:0. Addresses at or beyond the image depth read as all-zero words, which are no-ops.
- R3: Opcode 1 writes bits 3:0 of the word into the destination register. Opcode 2 copies source-1 into the destination. Reading register 6 returns `btn_i`.
- R4: Opcode 3 writes source-1 AND source-2. Opcode 4 writes source-1 OR source-2. Opcode 5 writes the bitwise inverse of source-1.
- R5: Opcode 6 writes source-1 plus source-2. Opcode 7 writes source-1 minus source-2. Both results wrap modulo 16.
- R6: Opcode 8 shifts source-1 by one place. When bit 1 of the word is 1, the shift is toward the MSB; when it is 0, the shift is toward the LSB. Bit 0 of the word supplies the vacated bit.
- R7: A write aimed at register 6 has no effect. `led_o` changes only when an instruction writes register 7.
- R8: Opcode 0xA tests the bit of source-1 that is selected by word bits 1:0. Opcode 0xB tests source-1 equal to source-2. Opcode 0xC tests source-1 greater than source-2. Opcode 0xD tests source-1 greater than or equal to source-2. All comparisons are unsigned.
- R9: When a condition is true, the word at PC+1 executes and execution then resumes at PC+3. When it is false, execution resumes at PC+2. A jump in the PC+1 slot takes effect in place of the resume address.
- R10: Opcode 0xE holds the program counter until the number of `tick_i` pulses given in bits 8:0 has been seen. A pulse in the instruction's first cycle counts. Execution then goes on to the following word.
- R11: Opcode 0xF loads bits 8:0 into the program counter.
- R12: Every instruction other than a stalled wait completes in exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| btn_i | input | 4 | Button levels, seen as register 6 |
| tick_i | input | 1 | Pulse input counted by the wait instruction |
| led_o | output | 4 | Contents of register 7 |

## Verification
The bench runs one loop program through every button value. Each pass exercises all arithmetic, shift and condition opcodes. Wrap-around in subtract would show up as a wrong LED nibble for button values below three. A swapped shift direction or fill bit would show up the same way. A condition that resumed at the wrong address would leave both branch literals or neither on the LEDs. The multi-pulse wait is probed after two of its three ticks: a counter that dropped the first-cycle tick, or released early, changes the LEDs too soon. A wait-while loop on equality must hold the LEDs for as long as the buttons match. If a jump in the shadow slot did not override the skip, the program would fall out of that loop.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
    localparam int DW     = 4;
    localparam int NREG   = 8;
    localparam int RSEL_W = $clog2(NREG);
    localparam int PC_W   = 9;
    localparam int IW     = 4 + 3 * RSEL_W;

    localparam logic [RSEL_W-1:0] BTN_REG = RSEL_W'(6);
    localparam logic [RSEL_W-1:0] LED_REG = RSEL_W'(7);

    typedef enum logic [3:0] {
        OP_NOP  = 4'h0,
        OP_LIT  = 4'h1,
        OP_MOV  = 4'h2,
        OP_AND  = 4'h3,
        OP_OR   = 4'h4,
        OP_INV  = 4'h5,
        OP_ADD  = 4'h6,
        OP_SUB  = 4'h7,
        OP_SHF  = 4'h8,
        OP_BIT  = 4'hA,
        OP_EQ   = 4'hB,
        OP_GT   = 4'hC,
        OP_GE   = 4'hD,
        OP_WAIT = 4'hE,
        OP_JMP  = 4'hF
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [RSEL_W-1:0] dst;
        logic [RSEL_W-1:0] s1;
        logic [RSEL_W-1:0] s2;
    } instr_t;

    typedef struct packed {
        logic [PC_W-1:0]          pc;
        logic [NREG-1:0][DW-1:0]  rf;
        logic [PC_W-1:0]          wcnt;
        logic                     skip;
    } core_t;
endpackage

// File: rtl/cpu_rom.sv
module cpu_rom
    import cpu_pkg::*;
#(
    parameter int                    DEPTH = 16,
    parameter logic [DEPTH*IW-1:0]   IMAGE = '0
) (
    input  logic [PC_W-1:0] addr,
    output logic [IW-1:0]   word
);
    localparam int SPAN = 2 ** PC_W;

    logic [IW-1:0] mem [SPAN];

    for (genvar g = 0; g < SPAN; g++) begin : g_word
        if (g < DEPTH) begin : g_fill
            assign mem[g] = IMAGE[g*IW +: IW];
        end else begin : g_blank
            assign mem[g] = '0;
        end
    end

    assign word = mem[addr];
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
(
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [3:0]    imm4,
    output logic [DW-1:0] res,
    output logic          we
);
    always_comb begin
        res = '0;
        we  = 1'b1;
        case (op)
            OP_LIT:  res = DW'(imm4);
            OP_MOV:  res = a;
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_INV:  res = ~a;
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_SHF:  res = imm4[1] ? {a[DW-2:0], imm4[0]} : {imm4[0], a[DW-1:1]};
            default: we  = 1'b0;
        endcase
    end
endmodule

// File: rtl/cpu_cond.sv
module cpu_cond
    import cpu_pkg::*;
(
    input  op_e                   op,
    input  logic [DW-1:0]         a,
    input  logic [DW-1:0]         b,
    input  logic [$clog2(DW)-1:0] sel,
    output logic                  taken
);
    always_comb begin
        case (op)
            OP_BIT:  taken = a[sel];
            OP_EQ:   taken = (a == b);
            OP_GT:   taken = (a > b);
            OP_GE:   taken = (a >= b);
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/nib_cpu.sv
module nib_cpu
    import cpu_pkg::*;
#(
    parameter int                      ROM_DEPTH = 16,
    parameter logic [ROM_DEPTH*IW-1:0] ROM_IMAGE = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] btn_i,
    input  logic          tick_i,
    output logic [DW-1:0] led_o
);
    localparam int SEL_W = $clog2(DW);

    core_t q, d;

    logic [IW-1:0]   word;
    instr_t          ins;
    logic [PC_W-1:0] imm;
    logic [DW-1:0]   src_a, src_b, alu_res;
    logic            alu_we, taken;
    logic [PC_W-1:0] step;
    logic [PC_W:0]   tally;

    cpu_rom #(.DEPTH(ROM_DEPTH), .IMAGE(ROM_IMAGE)) u_rom (
        .addr (q.pc),
        .word (word)
    );

    assign ins   = instr_t'(word);
    assign imm   = word[PC_W-1:0];
    assign src_a = (ins.s1 == BTN_REG) ? btn_i : q.rf[ins.s1];
    assign src_b = (ins.s2 == BTN_REG) ? btn_i : q.rf[ins.s2];

    cpu_alu u_alu (
        .op   (ins.op),
        .a    (src_a),
        .b    (src_b),
        .imm4 (word[3:0]),
        .res  (alu_res),
        .we   (alu_we)
    );

    cpu_cond u_cond (
        .op    (ins.op),
        .a     (src_a),
        .b     (src_b),
        .sel   (word[SEL_W-1:0]),
        .taken (taken)
    );

    always_comb begin
        d     = q;
        step  = q.skip ? PC_W'(2) : PC_W'(1);
        tally = {1'b0, q.wcnt} + (PC_W+1)'(tick_i);
        case (ins.op)
            OP_WAIT: begin
                if (tally >= {1'b0, imm}) begin
                    d.pc   = q.pc + step;
                    d.wcnt = '0;
                    d.skip = 1'b0;
                end else begin
                    d.wcnt = tally[PC_W-1:0];
                end
            end
            OP_JMP: begin
                d.pc   = imm;
                d.skip = 1'b0;
            end
            OP_BIT, OP_EQ, OP_GT, OP_GE: begin
                d.pc   = q.pc + (taken ? PC_W'(1) : PC_W'(2));
                d.skip = taken;
            end
            default: begin
                if (alu_we && ins.dst != BTN_REG) begin
                    d.rf[ins.dst] = alu_res;
                end
                d.pc   = q.pc + step;
                d.skip = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign led_o = q.rf[LED_REG];

    logic [PC_W-1:0] pc_cur;
    logic [PC_W-1:0] wcnt_cur;
    logic            skip_cur;
    assign pc_cur   = q.pc;
    assign wcnt_cur = q.wcnt;
    assign skip_cur = q.skip;
endmodule

// File: rtl/cpu_chk.sv
module cpu_chk
    import cpu_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            tick_i,
    input logic [DW-1:0]   led_o,
    input logic [IW-1:0]   word,
    input logic [PC_W-1:0] pc,
    input logic [PC_W-1:0] wcnt,
    input logic            skip
);
    logic [3:0]        op;
    logic [RSEL_W-1:0] dst;
    logic [PC_W-1:0]   imm;
    assign op  = word[IW-1:IW-4];
    assign dst = word[IW-5:IW-4-RSEL_W];
    assign imm = word[PC_W-1:0];

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (pc == '0 && wcnt == '0 && led_o == '0)); // R1

    AST_LED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(op >= 4'h1 && op <= 4'h8 && dst == LED_REG) |=> $stable(led_o)); // R7

    AST_COND_RESUME: assert property (@(posedge clk) disable iff (rst)
        (op >= 4'hA && op <= 4'hD) |=>
        ((pc == $past(pc) + PC_W'(1) && skip) || (pc == $past(pc) + PC_W'(2) && !skip))); // R9

    AST_SHADOW_SKIP: assert property (@(posedge clk) disable iff (rst)
        (op < 4'hA && skip) |=> (pc == $past(pc) + PC_W'(2))); // R9

    AST_WAIT_STALL: assert property (@(posedge clk) disable iff (rst)
        (op == 4'hE && !tick_i && wcnt < imm) |=> $stable(pc)); // R10

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (op == 4'hF) |=> (pc == $past(imm))); // R11

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (op < 4'hA && !skip) |=> (pc == $past(pc) + PC_W'(1))); // R12
endmodule

bind nib_cpu cpu_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_i),
    .led_o  (led_o),
    .word   (word),
    .pc     (pc_cur),
    .wcnt   (wcnt_cur),
    .skip   (skip_cur)
);

// File: tb/sim_nib_cpu.sv
`timescale 1ns/1ps
module sim_nib_cpu;
    localparam int DEPTH = 48;
    localparam int W     = 13;

    function automatic logic [W-1:0] al(input logic [3:0] op, input logic [2:0] dd,
                                        input logic [2:0] aa, input logic [2:0] bb);
        return {op, dd, aa, bb};
    endfunction
    function automatic logic [W-1:0] lit(input logic [2:0] dd, input logic [3:0] v);
        return {4'h1, dd, 2'b00, v};
    endfunction
    function automatic logic [W-1:0] wt(input logic [8:0] n);
        return {4'hE, n};
    endfunction
    function automatic logic [W-1:0] jp(input logic [8:0] t);
        return {4'hF, t};
    endfunction

    function automatic logic [W-1:0] prog_word(input int a);
        case (a)
            0:  return lit(3'd0, 4'd3);
            1:  return lit(3'd1, 4'd0);
            2:  return wt(9'd1);
            3:  return al(4'h6, 3'd7, 3'd0, 3'd6);
            4:  return wt(9'd1);
            5:  return al(4'h7, 3'd7, 3'd6, 3'd0);
            6:  return wt(9'd1);
            7:  return al(4'h3, 3'd7, 3'd6, 3'd0);
            8:  return wt(9'd1);
            9:  return al(4'h4, 3'd7, 3'd6, 3'd0);
            10: return wt(9'd1);
            11: return al(4'h5, 3'd7, 3'd6, 3'd0);
            12: return wt(9'd1);
            13: return al(4'h8, 3'd7, 3'd6, 3'b001);
            14: return wt(9'd1);
            15: return al(4'h8, 3'd7, 3'd6, 3'b010);
            16: return wt(9'd1);
            17: return lit(3'd6, 4'd5);
            18: return al(4'h2, 3'd7, 3'd6, 3'd0);
            19: return wt(9'd1);
            20: return al(4'hC, 3'd0, 3'd6, 3'd0);
            21: return lit(3'd7, 4'd9);
            22: return lit(3'd7, 4'd10);
            23: return wt(9'd1);
            24: return al(4'hA, 3'd0, 3'd6, 3'b010);
            25: return lit(3'd7, 4'd1);
            26: return lit(3'd7, 4'd2);
            27: return wt(9'd1);
            28: return al(4'hB, 3'd0, 3'd6, 3'd0);
            29: return lit(3'd7, 4'd11);
            30: return lit(3'd7, 4'd12);
            31: return wt(9'd1);
            32: return al(4'hD, 3'd0, 3'd6, 3'd0);
            33: return lit(3'd7, 4'd13);
            34: return lit(3'd7, 4'd14);
            35: return wt(9'd1);
            36: return wt(9'd3);
            37: return lit(3'd7, 4'd15);
            38: return wt(9'd1);
            39: return al(4'hB, 3'd0, 3'd6, 3'd0);
            40: return jp(9'd39);
            41: return '0;
            42: return lit(3'd7, 4'd6);
            43: return wt(9'd1);
            44: return jp(9'd3);
            default: return '0;
        endcase
    endfunction

    function automatic logic [DEPTH*W-1:0] build();
        logic [DEPTH*W-1:0] img;
        img = '0;
        for (int i = 0; i < DEPTH; i++) img[i*W +: W] = prog_word(i);
        return img;
    endfunction

    localparam logic [DEPTH*W-1:0] IMG = build();

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] btn = '0;
    logic       tick = 1'b0;
    logic [3:0] led;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    nib_cpu #(.ROM_DEPTH(DEPTH), .ROM_IMAGE(IMG)) u0 (
        .clk    (clk),
        .rst    (rst),
        .btn_i  (btn),
        .tick_i (tick),
        .led_o  (led)
    );

    task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        logic [3:0] add_e, prev;
        settle(3);
        chk("R1 led during reset", led, 4'd0);
        rst = 1'b0;
        settle(12);
        chk("R1 led after reset", led, 4'd0);

        for (int v = 0; v < 16; v++) begin
            btn   = 4'(v);
            add_e = 4'((v + 3) % 16);
            pulse(); settle(12);
            chk("R2 R5 add", led, add_e);
            pulse();
            chk("R12 before sub", led, add_e);
            @(negedge clk);
            chk("R12 R5 sub", led, 4'((v + 13) % 16));
            settle(12);
            pulse(); settle(12);
            chk("R4 and", led, 4'(v & 3));
            pulse(); settle(12);
            chk("R4 or", led, 4'(v | 3));
            pulse(); settle(12);
            chk("R4 not", led, 4'(15 - v));
            pulse(); settle(12);
            chk("R6 shift right fill 1", led, 4'(8 + v / 2));
            pulse(); settle(12);
            chk("R6 shift left fill 0", led, 4'((v * 2) % 16));
            pulse(); settle(12);
            chk("R7 R3 r6 write ignored copy", led, 4'(v));
            pulse(); settle(12);
            chk("R8 R9 gt", led, (v > 3) ? 4'd9 : 4'd10);
            pulse(); settle(12);
            chk("R8 R9 bit2", led, (((v / 4) % 2) == 1) ? 4'd1 : 4'd2);
            pulse(); settle(12);
            chk("R8 R9 eq", led, (v == 3) ? 4'd11 : 4'd12);
            pulse(); settle(12);
            prev = (v >= 3) ? 4'd13 : 4'd14;
            chk("R8 R9 ge", led, prev);
            pulse(); settle(12);
            chk("R10 wait entry", led, prev);
            pulse(); settle(12);
            pulse(); settle(12);
            chk("R10 two of three ticks", led, prev);
            pulse(); settle(12);
            chk("R10 R3 third tick literal", led, 4'd15);
            btn = 4'd3;
            pulse(); settle(20);
            chk("R9 wait-while holds", led, 4'd15);
            btn = 4'd0;
            settle(12);
            chk("R9 R11 wait-while exit", led, 4'd6);
        end

        btn = 4'd5;
        rst = 1'b1;
        settle(2);
        rst = 1'b0;
        settle(12);
        chk("R1 mid-run reset", led, 4'd0);
        pulse(); settle(12);
        chk("R1 restart at word 0", led, 4'd8);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule